// File: doc/BRIEF.md
# Two-Wire Register Port with Address Pointer

This block is a target on a two-wire serial control bus. It gives a bus controller read and write access to a small array of eight-bit registers. Access goes through an internal pointer. In a write transfer, the byte that follows the device address sets the pointer. Any later bytes in that transfer are stored in the register the pointer selects. A read transfer always begins at the register the pointer currently names.

Bit 7 of the pointer byte is an auto-increment flag. When it is set, the pointer moves on after each data byte, so one transfer can stream across neighbouring registers. When it is clear, the pointer stays on one register. To read a different register, the controller first writes only the pointer, then issues a repeated START followed by a read.

Both bus lines are oversampled by a system clock that runs at least ten times the bus clock rate. The data line is open-drain. It is split into an input and an output enable, and the enable pulls the line low when it is high. The register array sits on a plain parallel port with no back-pressure. A write is taken in the single cycle that `reg_wr_en` is high. Read data must be valid combinationally for whatever `reg_addr` currently shows. Neither side can stall the other.

Top module: `i2c_ptr_regport`

## Requirements
- R1: The device address is the seven bits `0011 00` followed by the level of `addr_sel`. The block acknowledges an address byte only when all seven bits match. Any other address gets no acknowledge, and the block ignores every byte up to the next START.
- R2: Bit 0 of the address byte selects the direction: 1 means read and 0 means write.
- R3: The first byte after a write address is loaded into the pointer and is not stored in any register. Bit 7 of that byte is the auto-increment flag, and bits 6:0 are the register index.
- R4: Each later write byte is acknowledged and stored, as one `reg_wr_en` pulse, at the pointer's register. If auto-increment is set, the pointer then advances by one.
- R5: After acknowledging a read address, the block drives the pointed register's contents onto the data line, most significant bit first.
- R6: After reset, the pointer is register 0 with auto-increment clear, and the data line is released.
- R7: With auto-increment clear, every byte of a read returns the same register, and repeated write bytes all land in the same register.
- R8: With auto-increment set, the pointer advances after each read byte that the controller acknowledges. From register 15, or from any index above 15, it wraps to 0.
- R9: A pointer index of 16 or more reads as 0x00, and writes to it are dropped.
- R10: When the controller does not acknowledge a read byte, the block releases the data line and stays silent until the next START. The pointer does not advance on that byte.
- R11: A START or repeated START at any bit restarts address reception. A STOP returns the block to idle without storing a partial byte.
- R12: The data-line output enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pulls the data line low |
| addr_sel | input | 1 | Least significant device address bit |
| reg_addr | output | 4 | Register index presented to the array |
| reg_wr_en | output | 1 | One-cycle write strobe to the array |
| reg_wdata | output | 8 | Write data to the array |
| reg_rdata | input | 8 | Read data from the array for `reg_addr` |

## Verification
A corrupted pointer or flag shows up in the next read transfer. The wrong register's value appears on the data line within about nine bus clocks of the address acknowledge. A stray write shows up immediately as an extra `reg_wr_en` pulse, or as a changed register when it is later read back. A wrong bit count or sequencer state shows up as a missing or misplaced acknowledge in the same byte, or as the data line being held low after a NACK. The bench checks for this by clocking the bus with no START and watching that the output enable stays low.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_WACK,
    ST_TX,
    ST_RACK
  } rp_state_e;
endpackage

// File: rtl/i2c_rp_linesync.sv
module i2c_rp_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] delayed;

  assign raw = {sda_in, scl_in};

  // Each line gets its own synchronizer chain, plus one extra stage
  // that keeps the previous sample for edge detection.
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain      <= '1;
        delayed[g] <= 1'b1;
      end else begin
        chain      <= {chain[STAGES-2:0], raw[g]};
        delayed[g] <= chain[STAGES-1];
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl       = synced[0];
  assign sda       = synced[1];
  assign scl_rise  = synced[0] & ~delayed[0];
  assign scl_fall  = ~synced[0] & delayed[0];
  assign bus_start = synced[0] & delayed[0] & delayed[1] & ~synced[1];
  assign bus_stop  = synced[0] & delayed[0] & ~delayed[1] & synced[1];
endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
  parameter int         DEPTH   = 16,
  parameter logic [7:0] RST_PTR = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       adv,
  output logic [6:0] ptr,
  output logic       in_range
);
  localparam logic [6:0] LAST = 7'(DEPTH - 1);

  logic auto_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= RST_PTR[6:0];
      auto_inc <= RST_PTR[7];
    end else if (load) begin
      ptr      <= load_val[6:0];
      auto_inc <= load_val[7];
    end else if (adv && auto_inc) begin
      ptr <= (ptr >= LAST) ? 7'd0 : ptr + 7'd1;
    end
  end

  assign in_range = (ptr <= LAST);

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (adv && !load && auto_inc && ptr >= LAST) |=> (ptr == 7'd0)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!load && !(adv && auto_inc)) |=> $stable(ptr)); // R7
endmodule

// File: rtl/i2c_ptr_regport.sv
module i2c_ptr_regport
  import i2c_rp_pkg::*;
#(
  parameter int         DEPTH       = 16,
  parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
  parameter logic [7:0] RST_PTR     = 8'h00,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  output logic [AW-1:0]     reg_addr,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_rp_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl(scl_s), .sda(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  rp_state_e         state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw_read, first_byte, mst_ack;
  logic              oe_r, wr_r, ld_r, adv_r;
  logic [BYTE_W-1:0] wdata_r;
  logic [6:0]        ptr;
  logic              ptr_ok;
  logic              addr_hit;
  logic [BYTE_W-1:0] rd_byte;

  i2c_rp_ptr #(.DEPTH(DEPTH), .RST_PTR(RST_PTR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ld_r), .load_val(shreg), .adv(adv_r),
    .ptr(ptr), .in_range(ptr_ok)
  );

  assign addr_hit = (shreg[7:2] == DEV_ADDR_HI) && (shreg[1] == addr_sel);
  assign rd_byte  = ptr_ok ? reg_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      rw_read    <= 1'b0;
      first_byte <= 1'b0;
      mst_ack    <= 1'b0;
      oe_r       <= 1'b0;
      wr_r       <= 1'b0;
      ld_r       <= 1'b0;
      adv_r      <= 1'b0;
      wdata_r    <= '0;
    end else begin
      wr_r  <= 1'b0;
      ld_r  <= 1'b0;
      adv_r <= 1'b0;
      if (bus_start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        oe_r    <= 1'b0;
      end else if (bus_stop) begin
        state <= ST_IDLE;
        oe_r  <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (addr_hit) begin
                oe_r    <= 1'b1;
                rw_read <= shreg[0];
                state   <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_read) begin
                shreg <= rd_byte;
                oe_r  <= ~rd_byte[7];
                state <= ST_TX;
              end else begin
                oe_r       <= 1'b0;
                first_byte <= 1'b1;
                state      <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              oe_r  <= 1'b1;
              state <= ST_WACK;
              if (first_byte) begin
                ld_r <= 1'b1;
              end else begin
                wr_r    <= ptr_ok;
                adv_r   <= 1'b1;
                wdata_r <= shreg;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_r       <= 1'b0;
              bit_cnt    <= '0;
              first_byte <= 1'b0;
              state      <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                oe_r  <= 1'b0;
                state <= ST_RACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                oe_r  <= ~shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_s;
              adv_r   <= ~sda_s;
            end else if (scl_fall) begin
              if (mst_ack) begin
                shreg   <= rd_byte;
                oe_r    <= ~rd_byte[7];
                bit_cnt <= '0;
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = oe_r;
  assign reg_wr_en = wr_r;
  assign reg_wdata = wdata_r;
  assign reg_addr  = ptr[AW-1:0];

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(oe_r) |-> !scl_s); // R12
  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_AACK) |-> (shreg[7:2] == DEV_ADDR_HI && shreg[1] == addr_sel)); // R1
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr_en |=> !reg_wr_en); // R4
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr_en |-> ptr_ok); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE) |-> !sda_oe); // R10
endmodule

// File: tb/i2c_ptr_regport_tb.sv
`timescale 1ns/1ps
module i2c_ptr_regport_tb;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b1;
  logic       sda_oe, reg_wr_en;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_line;
  logic [7:0] regs [16];

  int n_chk = 0;
  int n_err = 0;
  int wr_cnt = 0;
  int oe_hi = 0;
  int r12_viol = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  i2c_ptr_regport u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'hA0 ^ (8'(i) * 8'h11);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= init_val(i);
    end else if (reg_wr_en) begin
      regs[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl) r12_viol++;
    if (sda_oe) oe_hi++;
    oe_prev = sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~mack);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b001100, addr_sel, rd};
  endfunction

  // Sets the pointer, then a repeated START into a read.
  task automatic point_and_read(input logic [7:0] p, input string tag);
    logic a;
    bus_start(); wbyte(dev(1'b0), a); check({tag, " waddr ack"}, a, 1);
    wbyte(p, a); check({tag, " ptr ack"}, a, 1);
    bus_start(); wbyte(dev(1'b1), a); check({tag, " raddr ack"}, a, 1);
  endtask

  task automatic t_reset();
    check("R6 oe after reset", sda_oe, 0);
    check("R6 wr_en after reset", reg_wr_en, 0);
  endtask

  task automatic t_read_default();
    logic a; logic [7:0] d;
    bus_start(); wbyte(dev(1'b1), a); check("R1 R2 read address ack", a, 1);
    rbyte(1'b1, d); check("R5 R6 default pointer byte0", d, init_val(0));
    rbyte(1'b0, d); check("R7 no increment byte1", d, init_val(0));
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic a; logic [7:0] d; int w0;
    w0 = wr_cnt;
    bus_start(); wbyte({6'b001100, ~addr_sel, 1'b0}, a); check("R1 select bit mismatch nack", a, 0);
    wbyte(8'h83, a); wbyte(8'h55, a); bus_stop();
    bus_start(); wbyte(8'hAA, a); check("R1 foreign address nack", a, 0); bus_stop();
    check("R1 no writes after mismatch", wr_cnt - w0, 0);
    bus_start(); wbyte(dev(1'b1), a);
    rbyte(1'b0, d); check("R3 pointer untouched by ignored bytes", d, init_val(0));
    bus_stop();
  endtask

  task automatic t_incr_write_wrap();
    logic a; logic [7:0] d; int w0;
    w0 = wr_cnt;
    bus_start(); wbyte(dev(1'b0), a);
    wbyte(8'h8E, a); check("R3 pointer byte ack", a, 1);
    check("R3 pointer byte not stored", wr_cnt - w0, 0);
    wbyte(8'h11, a); check("R4 data ack", a, 1);
    wbyte(8'h22, a); wbyte(8'h33, a);
    bus_stop();
    check("R4 three write strobes", wr_cnt - w0, 3);
    check("R8 write wrapped to reg0", regs[0], 8'h33);
    point_and_read(8'h8E, "R11");
    rbyte(1'b1, d); check("R8 stream reg14", d, 8'h11);
    rbyte(1'b1, d); check("R8 stream reg15", d, 8'h22);
    rbyte(1'b0, d); check("R8 stream wrap reg0", d, 8'h33);
    bus_stop();
  endtask

  task automatic t_fixed_write();
    logic a; logic [7:0] d;
    bus_start(); wbyte(dev(1'b0), a); wbyte(8'h05, a);
    wbyte(8'hC1, a); wbyte(8'hC2, a); bus_stop();
    point_and_read(8'h05, "R7");
    rbyte(1'b1, d); check("R7 fixed read 1", d, 8'hC2);
    rbyte(1'b1, d); check("R7 fixed read 2", d, 8'hC2);
    rbyte(1'b0, d); check("R7 fixed read 3", d, 8'hC2);
    bus_stop();
    point_and_read(8'h06, "R7");
    rbyte(1'b0, d); check("R7 neighbour untouched", d, init_val(6));
    bus_stop();
  endtask

  task automatic t_out_of_range();
    logic a; logic [7:0] d; int w0;
    w0 = wr_cnt;
    bus_start(); wbyte(dev(1'b0), a); wbyte(8'h14, a);
    wbyte(8'h99, a); check("R9 out of range byte acked", a, 1);
    bus_stop();
    check("R9 out of range write dropped", wr_cnt - w0, 0);
    point_and_read(8'h14, "R9");
    rbyte(1'b0, d); check("R9 out of range reads zero", d, 0);
    bus_stop();
    point_and_read(8'h94, "R8");
    rbyte(1'b1, d); check("R9 reads zero with increment", d, 0);
    rbyte(1'b0, d); check("R8 wrap from beyond last", d, 8'h33);
    bus_stop();
  endtask

  task automatic t_nack();
    logic a; logic [7:0] d; int h0;
    point_and_read(8'h81, "R10");
    rbyte(1'b0, d); check("R10 read reg1", d, init_val(1));
    h0 = oe_hi;
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    check("R10 line released after nack", oe_hi - h0, 0);
    bus_stop();
    bus_start(); wbyte(dev(1'b1), a);
    rbyte(1'b0, d); check("R10 no advance on nack", d, init_val(1));
    bus_stop();
  endtask

  task automatic t_restart();
    logic a; logic [7:0] d; int w0;
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start(); wbyte(dev(1'b1), a); check("R11 start mid byte restarts", a, 1);
    rbyte(1'b0, d); check("R11 read after restart", d, init_val(1));
    bus_stop();
    w0 = wr_cnt;
    bus_start(); wbyte(dev(1'b0), a); wbyte(8'h02, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    check("R11 partial byte not stored", wr_cnt - w0, 0);
    bus_start(); wbyte(dev(1'b1), a);
    rbyte(1'b0, d); check("R11 pointer from aborted write", d, init_val(2));
    bus_stop();
  endtask

  task automatic t_addr_sel();
    logic a; logic [7:0] d;
    addr_sel = 1'b0; tick(Q);
    bus_start(); wbyte(8'h32, a); check("R1 old select level nack", a, 0); bus_stop();
    bus_start(); wbyte(dev(1'b1), a); check("R1 new select level ack", a, 1);
    rbyte(1'b0, d); check("R1 R5 read with select low", d, init_val(2));
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_read_default();
    t_bad_addr();
    t_incr_write_wrap();
    t_fixed_write();
    t_out_of_range();
    t_nack();
    t_restart();
    t_addr_sel();
    check("R12 enable moved only with clock low", r12_viol, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule